// File: doc/BRIEF.md
# Egress Time-Aware Gate Scheduler

This block drives the eight transmit gates of one egress port from a cyclic gate control list. Each list entry carries an 8-bit gate mask and a duration in nanoseconds. The block watches a free-running nanosecond time input and starts the list at a programmable absolute base time. It keeps every later cycle phase-locked to that anchor. A downstream transmission selector uses `gate_open` to decide which traffic classes may be offered for transmission.

All gate events are placed on a 200 ns slot grid. Each event pulses `gate_evt` and reports the slot number of the event on `evt_slot`. An external checker can compare the slot numbers of several ports to find two ports that fire in the same slot. The list and its length are written only while the scheduler is disabled. When `enable` rises, a controller scans the list, adds up the cycle length and rejects bad configurations. It then aligns the first boundary and runs the list.

Controller states: IDLE (disabled, gates open, writes accepted), CHECK (scan entries and sum the cycle), ALIGN (advance the start by whole cycles until it is not in the past), WAIT (gates open until the start slot), RUN (apply entries in turn) and FAULT (configuration rejected). Transitions:
- IDLE to CHECK when `enable` rises with a legal count, or IDLE to FAULT when the count is illegal.
- CHECK to FAULT on a zero-slot entry, or CHECK to ALIGN after the last entry.
- ALIGN to WAIT once the start slot is at or after the current slot.
- WAIT to RUN at the start slot.
- Any state to IDLE when `enable` is low.

Top module: `tas_gate_sched`

## Requirements
- R1: While running, `gate_open[i]` equals bit i of the current entry's mask for all eight classes. Class 7 has no special treatment.
- R2: Entries are applied in index order 0..count-1 and then wrap to entry 0. The cycle length is the sum of the entry durations in slots.
- R3: A duration of d ns counts as floor(d/200) slots. The time input is seen as slot floor(now_ns/200). Outputs follow the time input with a two-clock latency.
- R4: With a base in the future, gates are all open (8'hFF) and no event is emitted before slot floor(base_ns/200). At that slot, entry 0 is applied.
- R5: With a base in the past, the list starts at the first slot base_slot + k*cycle (k a whole number) that is not before the current slot.
- R6: Every gate event, including the first, pulses `gate_evt` for one clock with `evt_slot` equal to the event's slot. Successive event slots strictly increase.
- R7: Entry writes and count writes take effect only while `enable` is low and the controller is in IDLE. Writes at other times have no effect.
- R8: A count of 0 or above 16, or any entry shorter than one slot, makes `cfg_err` 1 with gates all open and no events until `enable` goes low.
- R9: One clock after `enable` is seen low, gates are all open, `gate_evt` is 0 and `cfg_err` is 0.
- R10: After reset, `gate_open` is 8'hFF, `gate_evt` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the schedule while high |
| now_ns | input | 48 | Free-running time in ns |
| base_ns | input | 48 | Absolute start time in ns |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | 4 | Entry index to write |
| ent_mask | input | 8 | Gate mask, bit i opens class i |
| ent_intv_ns | input | 32 | Entry duration in ns |
| cnt_we | input | 1 | Entry count write strobe |
| cnt_val | input | 5 | Number of entries in use (1..16) |
| gate_open | output | 8 | Per-class gate state |
| gate_evt | output | 1 | One-clock pulse on each gate event |
| evt_slot | output | 48 | Slot number of the latest event |
| cfg_err | output | 1 | Configuration rejected |

## Verification
The time input advances one slot per clock, and every output is compared with an arithmetic model of the list for each slot. Two-entry lists with masks that split class 7 from the rest, and durations that are not slot multiples, show correct per-class gating and floor quantization. A sixteen-entry list with mixed durations shows index order and wrap. A single-entry list shows events recurring with an unchanged mask. Base times are tried in the future, in the past off-boundary, and exactly a whole number of cycles back, which separates the WAIT path from the ALIGN arithmetic. Illegal counts, a sub-slot entry and writes made while running each show whether rejection and write locking leave the outputs untouched.

// File: rtl/tas_pkg.sv
package tas_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ALIGN,
        ST_WAIT,
        ST_RUN,
        ST_FAULT
    } tas_state_e;
endpackage

// File: rtl/tas_slot_clock.sv
module tas_slot_clock #(
    parameter int TIME_W  = 48,
    parameter int SLOT_NS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_ns,
    output logic [TIME_W-1:0] now_slot
);
    // Registered conversion of the nanosecond time into slot units.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_slot <= '0;
        else        now_slot <= now_ns / TIME_W'(SLOT_NS);
    end
endmodule

// File: rtl/tas_gcl_table.sv
module tas_gcl_table #(
    parameter int NUM_TC  = 8,
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 4,
    parameter int INTV_W  = 32,
    parameter int SLOT_NS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_allow,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [NUM_TC-1:0] ent_mask,
    input  logic [INTV_W-1:0] ent_intv_ns,
    input  logic              cnt_we,
    input  logic [IDX_W:0]    cnt_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [NUM_TC-1:0] rd_mask,
    output logic [INTV_W-1:0] rd_slots,
    output logic [IDX_W:0]    len
);
    logic [NUM_TC-1:0] mask_q  [DEPTH];
    logic [INTV_W-1:0] slots_q [DEPTH];
    logic [INTV_W-1:0] wr_slots;

    // Durations are stored already quantized to whole slots.
    assign wr_slots = ent_intv_ns / INTV_W'(SLOT_NS);

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g]  <= '1;
                slots_q[g] <= '0;
            end else if (wr_allow && ent_we && ent_idx == IDX_W'(g)) begin
                mask_q[g]  <= ent_mask;
                slots_q[g] <= wr_slots;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 len <= '0;
        else if (wr_allow && cnt_we) len <= cnt_val;
    end

    assign rd_mask  = mask_q[rd_idx];
    assign rd_slots = slots_q[rd_idx];

    // R7: the count cannot move while writes are locked
    assert_locked_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(len));
endmodule

// File: rtl/tas_gate_fsm.sv
module tas_gate_fsm
    import tas_pkg::*;
#(
    parameter int NUM_TC  = 8,
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 4,
    parameter int INTV_W  = 32,
    parameter int TIME_W  = 48,
    parameter int SLOT_NS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TIME_W-1:0] now_slot,
    input  logic [TIME_W-1:0] base_ns,
    input  logic [NUM_TC-1:0] rd_mask,
    input  logic [INTV_W-1:0] rd_slots,
    input  logic [IDX_W:0]    len,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              idle,
    output logic [NUM_TC-1:0] gate_open,
    output logic              gate_evt,
    output logic [TIME_W-1:0] evt_slot,
    output logic              cfg_err
);
    localparam int LEN_W = IDX_W + 1;
    localparam logic [NUM_TC-1:0] ALL_OPEN = '1;

    tas_state_e        st_q, st_d;
    logic [IDX_W-1:0]  scan_q, cur_q, last_idx, nxt_idx;
    logic [TIME_W-1:0] cycle_q, deadline_q, base_slot, step;
    logic [NUM_TC-1:0] gate_q;
    logic              evt_q, len_ok, fire;
    logic [TIME_W-1:0] evt_slot_q;

    assign base_slot = base_ns / TIME_W'(SLOT_NS);
    assign step      = TIME_W'(rd_slots);
    assign len_ok    = (len != '0) && (len <= LEN_W'(DEPTH));
    assign last_idx  = IDX_W'(len - LEN_W'(1));
    assign nxt_idx   = (cur_q == last_idx) ? '0 : cur_q + IDX_W'(1);
    assign fire      = now_slot >= deadline_q;

    always_comb begin
        unique case (st_q)
            ST_CHECK: rd_idx = scan_q;
            ST_WAIT:  rd_idx = '0;
            default:  rd_idx = nxt_idx;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (enable) st_d = len_ok ? ST_CHECK : ST_FAULT;
            ST_CHECK: if (!enable)              st_d = ST_IDLE;
                      else if (rd_slots == '0)  st_d = ST_FAULT;
                      else if (scan_q == last_idx) st_d = ST_ALIGN;
            ST_ALIGN: if (!enable)              st_d = ST_IDLE;
                      else if (deadline_q >= now_slot) st_d = ST_WAIT;
            ST_WAIT:  if (!enable)              st_d = ST_IDLE;
                      else if (fire)            st_d = ST_RUN;
            ST_RUN:   if (!enable)              st_d = ST_IDLE;
            ST_FAULT: if (!enable)              st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q     <= '0;
            cur_q      <= '0;
            cycle_q    <= '0;
            deadline_q <= '0;
            gate_q     <= ALL_OPEN;
            evt_q      <= 1'b0;
            evt_slot_q <= '0;
        end else begin
            evt_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    scan_q     <= '0;
                    cycle_q    <= '0;
                    deadline_q <= base_slot;
                    gate_q     <= ALL_OPEN;
                end
                ST_CHECK: begin
                    cycle_q <= cycle_q + step;
                    scan_q  <= scan_q + IDX_W'(1);
                end
                ST_ALIGN: begin
                    if (deadline_q < now_slot) deadline_q <= deadline_q + cycle_q;
                end
                ST_WAIT, ST_RUN: begin
                    if (fire && enable) begin
                        cur_q      <= rd_idx;
                        gate_q     <= rd_mask;
                        evt_q      <= 1'b1;
                        evt_slot_q <= deadline_q;
                        deadline_q <= deadline_q + step;
                    end
                end
                ST_FAULT: gate_q <= ALL_OPEN;
                default:  gate_q <= ALL_OPEN;
            endcase
            if (!enable) gate_q <= ALL_OPEN;
        end
    end

    assign idle      = (st_q == ST_IDLE);
    assign gate_open = gate_q;
    assign gate_evt  = evt_q;
    assign evt_slot  = evt_slot_q;
    assign cfg_err   = (st_q == ST_FAULT);

    // Support state for the slot-ordering check
    logic              prev_ok_q;
    logic [TIME_W-1:0] prev_slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ok_q   <= 1'b0;
            prev_slot_q <= '0;
        end else if (st_q == ST_IDLE) begin
            prev_ok_q <= 1'b0;
        end else if (evt_q) begin
            prev_ok_q   <= 1'b1;
            prev_slot_q <= evt_slot_q;
        end
    end

    assert_slot_rising_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_evt && prev_ok_q) |-> (evt_slot > prev_slot_q));
    assert_evt_not_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |-> (now_slot >= evt_slot));
    assert_evt_from_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_evt |-> ($past(st_q) == ST_WAIT || $past(st_q) == ST_RUN));
    assert_fault_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (gate_open == ALL_OPEN && !gate_evt));
    assert_disable_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_open == ALL_OPEN && !gate_evt));
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
    parameter int NUM_TC  = 8,
    parameter int DEPTH   = 16,
    parameter int IDX_W   = 4,
    parameter int INTV_W  = 32,
    parameter int TIME_W  = 48,
    parameter int SLOT_NS = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TIME_W-1:0] now_ns,
    input  logic [TIME_W-1:0] base_ns,
    input  logic              ent_we,
    input  logic [IDX_W-1:0]  ent_idx,
    input  logic [NUM_TC-1:0] ent_mask,
    input  logic [INTV_W-1:0] ent_intv_ns,
    input  logic              cnt_we,
    input  logic [IDX_W:0]    cnt_val,
    output logic [NUM_TC-1:0] gate_open,
    output logic              gate_evt,
    output logic [TIME_W-1:0] evt_slot,
    output logic              cfg_err
);
    logic [TIME_W-1:0] now_slot;
    logic [IDX_W-1:0]  rd_idx;
    logic [NUM_TC-1:0] rd_mask;
    logic [INTV_W-1:0] rd_slots;
    logic [IDX_W:0]    len;
    logic              idle, wr_allow;

    assign wr_allow = idle && !enable;

    tas_slot_clock #(.TIME_W(TIME_W), .SLOT_NS(SLOT_NS)) u_clk (
        .clk(clk), .rst_n(rst_n), .now_ns(now_ns), .now_slot(now_slot)
    );

    tas_gcl_table #(.NUM_TC(NUM_TC), .DEPTH(DEPTH), .IDX_W(IDX_W),
                    .INTV_W(INTV_W), .SLOT_NS(SLOT_NS)) u_tbl (
        .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow),
        .ent_we(ent_we), .ent_idx(ent_idx), .ent_mask(ent_mask),
        .ent_intv_ns(ent_intv_ns), .cnt_we(cnt_we), .cnt_val(cnt_val),
        .rd_idx(rd_idx), .rd_mask(rd_mask), .rd_slots(rd_slots), .len(len)
    );

    tas_gate_fsm #(.NUM_TC(NUM_TC), .DEPTH(DEPTH), .IDX_W(IDX_W),
                   .INTV_W(INTV_W), .TIME_W(TIME_W), .SLOT_NS(SLOT_NS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .now_slot(now_slot),
        .base_ns(base_ns), .rd_mask(rd_mask), .rd_slots(rd_slots), .len(len),
        .rd_idx(rd_idx), .idle(idle), .gate_open(gate_open),
        .gate_evt(gate_evt), .evt_slot(evt_slot), .cfg_err(cfg_err)
    );
endmodule

// File: tb/tb_tas_gate_sched.sv
`timescale 1ns/1ps
module tb_tas_gate_sched;
    localparam longint P = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [47:0] now_ns = '0;
    logic [47:0] base_ns = '0;
    logic        ent_we = 1'b0;
    logic [3:0]  ent_idx = '0;
    logic [7:0]  ent_mask = '0;
    logic [31:0] ent_intv_ns = '0;
    logic        cnt_we = 1'b0;
    logic [4:0]  cnt_val = '0;
    logic [7:0]  gate_open;
    logic        gate_evt;
    logic [47:0] evt_slot;
    logic        cfg_err;

    int errors = 0;
    int checks = 0;

    longint m_slots [16];
    logic [7:0] m_mask [16];
    int     m_len;
    longint m_start, m_cycle;

    always #2.5 clk = ~clk;

    tas_gate_sched dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .now_ns(now_ns),
        .base_ns(base_ns), .ent_we(ent_we), .ent_idx(ent_idx),
        .ent_mask(ent_mask), .ent_intv_ns(ent_intv_ns), .cnt_we(cnt_we),
        .cnt_val(cnt_val), .gate_open(gate_open), .gate_evt(gate_evt),
        .evt_slot(evt_slot), .cfg_err(cfg_err)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mask(longint s);
        longint pos, acc;
        if (s < m_start) return 8'hFF;
        pos = (s - m_start) % m_cycle;
        acc = 0;
        for (int i = 0; i < m_len; i++) begin
            acc += m_slots[i];
            if (pos < acc) return m_mask[i];
        end
        return 8'hFF;
    endfunction

    function automatic bit exp_evt(longint s);
        longint pos, acc;
        if (s < m_start) return 1'b0;
        pos = (s - m_start) % m_cycle;
        acc = 0;
        for (int i = 0; i < m_len; i++) begin
            if (pos == acc) return 1'b1;
            acc += m_slots[i];
        end
        return 1'b0;
    endfunction

    task automatic wr_entry(int idx, logic [7:0] mask, longint intv);
        @(negedge clk);
        ent_we = 1'b1; ent_idx = 4'(idx); ent_mask = mask; ent_intv_ns = 32'(intv);
        @(negedge clk);
        ent_we = 1'b0;
        m_mask[idx]  = mask;
        m_slots[idx] = intv / 200;
    endtask

    task automatic wr_count(int n);
        @(negedge clk);
        cnt_we = 1'b1; cnt_val = 5'(n);
        @(negedge clk);
        cnt_we = 1'b0;
        m_len = n;
    endtask

    task automatic disable_and_check();
        enable = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 gates after disable", gate_open, 8'hFF);
        chk("R9 evt after disable", gate_evt, 0);
        chk("R9 err after disable", cfg_err, 0);
    endtask

    // Run the loaded list from a frozen time P with the given base.
    task automatic run_case(string req, longint base, int nsteps, bit try_lock);
        longint bs, s;
        m_cycle = 0;
        for (int i = 0; i < m_len; i++) m_cycle += m_slots[i];
        bs = base / 200;
        if (bs >= P) m_start = bs;
        else m_start = bs + ((P - bs + m_cycle - 1) / m_cycle) * m_cycle;
        @(negedge clk);
        now_ns = 48'(P * 200); base_ns = 48'(base);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (40) @(negedge clk);
        for (int k = 1; k <= nsteps; k++) begin
            now_ns = 48'((P + k) * 200);
            if (try_lock && k == nsteps / 2) begin
                ent_we = 1'b1; ent_idx = 4'd0; ent_mask = ~m_mask[0]; ent_intv_ns = 32'd200;
                cnt_we = 1'b1; cnt_val = 5'd1;
            end else begin
                ent_we = 1'b0; cnt_we = 1'b0;
            end
            @(negedge clk);
            if (k >= 2) begin
                s = P + k - 1;
                chk(req, gate_open, exp_mask(s));
                chk(req, gate_evt, exp_evt(s));
                if (exp_evt(s)) chk("R6 event slot", evt_slot, s);
                chk("R8 no error while running", cfg_err, 0);
            end
        end
        disable_and_check();
    endtask

    task automatic fault_case(string req);
        @(negedge clk);
        now_ns = 48'(P * 200); base_ns = 48'(P * 200);
        enable = 1'b1;
        repeat (30) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            now_ns = 48'((P + k) * 200);
            @(negedge clk);
            chk(req, cfg_err, 1);
            chk(req, gate_open, 8'hFF);
            chk(req, gate_evt, 0);
        end
        disable_and_check();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 gates in reset", gate_open, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 gates after reset", gate_open, 8'hFF);
        chk("R10 evt after reset", gate_evt, 0);
        chk("R10 err after reset", cfg_err, 0);

        // R1 R3 R4: two entries, class 7 alone then the rest, base in the future
        wr_entry(0, 8'h80, 350);
        wr_entry(1, 8'h7F, 950);
        wr_count(2);
        run_case("R1 R3 R4 future base", (P + 5) * 200 + 77, 40, 1'b0);

        // R7: writes while running are ignored
        run_case("R7 write while running", (P + 3) * 200, 40, 1'b1);

        // R5: base exactly two cycles in the past
        run_case("R5 base on boundary", (P - 10) * 200, 30, 1'b0);

        // R2 R5: sixteen entries, base off-boundary in the past
        for (int i = 0; i < 16; i++)
            wr_entry(i, 8'(i * 17 + 3), (i % 3 + 1) * 200 + 40);
        wr_count(16);
        run_case("R2 R5 sixteen entries", (P - 37) * 200, 80, 1'b0);

        // R2 R6: single entry recurs every two slots
        wr_entry(0, 8'h00, 400);
        wr_count(1);
        run_case("R2 R6 single entry", (P + 2) * 200, 20, 1'b0);

        // R8: illegal counts and a sub-slot entry
        wr_count(0);
        fault_case("R8 count zero");
        wr_count(17);
        fault_case("R8 count too large");
        wr_entry(0, 8'h0F, 600);
        wr_entry(1, 8'hF0, 150);
        wr_count(2);
        fault_case("R8 short entry");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule